// File: doc/BRIEF.md
# Circular Reorder Buffer with Precise Flush

This block holds in-flight instructions of an out-of-order core in a ring of `DEPTH` slots so that they leave in program order. Dispatch writes an entry at the tail: destination register, PC and a store flag. The slot index comes back as the entry's tag. Execution units report results by tag on `NCMP` completion ports. Each report carries a result value and can also flag an exception or a mispredicted branch. Results stay inside the ring until their entry reaches the head. Only then do they appear on the retire port that feeds the architectural register file.

Two recovery paths exist. A faulting entry is only acted on when it reaches the head. It is then not committed, every entry is discarded, and the faulting PC is presented for the handler. A mispredicted branch is acted on in the cycle its completion arrives. The branch stays and later retires normally. Every entry younger than it is dropped by pulling the tail back to the slot after the branch, and a fetch redirect target is presented. One slot is never filled, so an equal head and tail always means empty.

Top module: `rob_core`

## Requirements
- R1: After reset, and whenever head equals tail, `rob_empty` is 1, `rob_full` is 0, and neither `ret_valid` nor `exc_valid` is asserted.
- R2: `rob_full` is 1 exactly when `DEPTH-1` entries are held. While full, `disp_ready` is 0 and a dispatch attempt changes nothing.
- R3: `disp_tag` shows the slot the next dispatch will use. It advances by one per accepted dispatch and wraps from `DEPTH-1` to 0.
- R4: Only the head entry retires, at most one per cycle. Retirement happens only once that entry is complete. `ret_valid`, `ret_dst`, `ret_pc` and `ret_store` show that entry combinationally, and the slot is freed at the next edge. A younger complete entry waits behind an incomplete head.
- R5: When the head entry is complete with its exception flag set, `exc_valid` is 1, `exc_pc` is its PC, and `ret_valid` is 0. From the next cycle the buffer is empty.
- R6: A completion with the mispredict flag on a held entry asserts `redir_valid` with `redir_pc` equal to that port's target in the same cycle. From the next cycle the tail is the slot after the branch. The branch entry itself stays and retires normally.
- R7: If several completion ports flag a mispredict in one cycle, the one oldest in program order (nearest the head) is taken.
- R8: When the buffer is neither full nor empty, a retirement and a dispatch in the same cycle are both accepted.
- R9: An exception at the head or a taken mispredict blocks dispatch in that cycle (`disp_ready` is 0).
- R10: A completion whose tag names a slot not holding an entry (never written, retired, or squashed) is ignored. A later entry dispatched into that slot does not retire until it gets its own completion.
- R11: `ret_data` equals the value delivered by that entry's completion. A result reaches the retire port only when its entry is at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Dispatch accepted this cycle |
| disp_dst | input | REG_W | Destination register of the new entry |
| disp_pc | input | PC_W | PC of the new entry |
| disp_store | input | 1 | New entry is a store |
| disp_tag | output | IDX_W | Slot the next dispatch occupies |
| cmp_valid | input | NCMP | Per-port completion strobe |
| cmp_tag | input | NCMP*IDX_W | Per-port slot tag, port p in bits [p*IDX_W +: IDX_W] |
| cmp_data | input | NCMP*DATA_W | Per-port result value |
| cmp_exc | input | NCMP | Per-port exception flag |
| cmp_mispred | input | NCMP | Per-port mispredicted-branch flag |
| cmp_target | input | NCMP*PC_W | Per-port correct fetch target |
| ret_valid | output | 1 | Head entry commits this cycle |
| ret_dst | output | REG_W | Committed destination register |
| ret_data | output | DATA_W | Committed result |
| ret_pc | output | PC_W | Committed PC |
| ret_store | output | 1 | Committed entry is a store |
| exc_valid | output | 1 | Head entry faults, whole buffer flushed at the edge |
| exc_pc | output | PC_W | PC of the faulting entry |
| redir_valid | output | 1 | Mispredict taken, younger entries squashed at the edge |
| redir_pc | output | PC_W | Fetch redirect target |
| rob_empty | output | 1 | Buffer holds no entries |
| rob_full | output | 1 | Buffer holds DEPTH-1 entries |

## Verification
The checker watches properties that hold in every cycle. Empty and full never coincide, and an empty buffer neither commits nor faults. Full and every flush cycle block dispatch. A commit never coincides with a fault, a fault leaves the buffer empty, and the tail tag moves only by one slot per accepted dispatch. Properties that depend on contents cannot be checked that way. These are dispatch-order commit under shuffled completion, which of two same-cycle mispredicts wins, where the tail lands after a squash, and a late completion to a squashed slot not marking its new occupant. Only the bench's scenarios show them, against a reference model of the requirements.

// File: rtl/rob_pkg.sv
// Package: shared types of the reorder buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package rob_pkg;

    // What the head slot does in the current cycle.
    typedef enum logic [1:0] {
        HEAD_WAIT   = 2'd0,
        HEAD_COMMIT = 2'd1,
        HEAD_FAULT  = 2'd2
    } head_act_e;

endpackage

// File: rtl/rob_ring_ptr.sv
// Module: head/tail pointer pair of the ring with full/empty decode.
// Assumes: push is never raised together with rewind or flush_all; one slot
// stays unused so head == tail always means empty.
module rob_ring_ptr #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush_all,
    input  logic             rewind,
    input  logic [IDX_W-1:0] rewind_to,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             full,
    output logic             empty
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Decode occupancy from the pointer pair.
    always_comb begin
        empty = (head == tail);
        full  = (step(tail) == head);
    end

    // Advance, rewind or collapse the pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
        end else if (flush_all) begin
            tail <= head;
        end else begin
            if (pop)
                head <= step(head);
            if (rewind)
                tail <= step(rewind_to);
            else if (push)
                tail <= step(tail);
        end
    end

endmodule

// File: rtl/rob_slot_array.sv
// Module: per-slot storage of the ring (control bits and payload).
// Assumes: at most one completion port names a given slot per cycle;
// squash, clear and free win over a same-cycle completion.
module rob_slot_array #(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int NCMP   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [REG_W-1:0]       wr_dst,
    input  logic [PC_W-1:0]        wr_pc,
    input  logic                   wr_store,
    input  logic [NCMP-1:0]        cmp_valid,
    input  logic [NCMP*IDX_W-1:0]  cmp_tag,
    input  logic [NCMP*DATA_W-1:0] cmp_data,
    input  logic [NCMP-1:0]        cmp_exc,
    input  logic                   clear_all,
    input  logic [DEPTH-1:0]       squash_mask,
    input  logic                   free_en,
    input  logic [IDX_W-1:0]       free_idx,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [DEPTH-1:0]       vld_vec,
    output logic                   rd_vld,
    output logic                   rd_done,
    output logic                   rd_exc,
    output logic [REG_W-1:0]       rd_dst,
    output logic [PC_W-1:0]        rd_pc,
    output logic                   rd_store,
    output logic [DATA_W-1:0]      rd_data
);

    logic [DEPTH-1:0]        done_vec;
    logic [DEPTH-1:0]        exc_vec;
    logic [DEPTH-1:0]        store_vec;
    logic [DEPTH*REG_W-1:0]  dst_flat;
    logic [DEPTH*PC_W-1:0]   pc_flat;
    logic [DEPTH*DATA_W-1:0] data_flat;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic              hit, hit_exc;
        logic [DATA_W-1:0] hit_data;
        logic              vld_q, done_q, exc_q, store_q;
        logic [REG_W-1:0]  dst_q;
        logic [PC_W-1:0]   pc_q;
        logic [DATA_W-1:0] data_q;
        logic              kill;

        // Find a completion port addressing this slot.
        always_comb begin
            hit      = 1'b0;
            hit_exc  = 1'b0;
            hit_data = '0;
            for (int p = 0; p < NCMP; p++) begin
                if (cmp_valid[p] && cmp_tag[p*IDX_W +: IDX_W] == IDX_W'(i)) begin
                    hit      = 1'b1;
                    hit_exc  = cmp_exc[p];
                    hit_data = cmp_data[p*DATA_W +: DATA_W];
                end
            end
            kill = clear_all || squash_mask[i] || (free_en && free_idx == IDX_W'(i));
        end

        // Slot lifecycle: allocate, complete, release.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                done_q <= 1'b0;
                exc_q  <= 1'b0;
            end else if (kill) begin
                vld_q  <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                vld_q  <= 1'b1;
                done_q <= 1'b0;
                exc_q  <= 1'b0;
            end else if (hit && vld_q) begin
                done_q <= 1'b1;
                exc_q  <= hit_exc;
            end
        end

        // Payload capture at dispatch and at completion.
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
                dst_q   <= wr_dst;
                pc_q    <= wr_pc;
                store_q <= wr_store;
            end
            if (hit && vld_q && !kill)
                data_q <= hit_data;
        end

        assign vld_vec[i]                    = vld_q;
        assign done_vec[i]                   = done_q;
        assign exc_vec[i]                    = exc_q;
        assign store_vec[i]                  = store_q;
        assign dst_flat[i*REG_W +: REG_W]    = dst_q;
        assign pc_flat[i*PC_W +: PC_W]       = pc_q;
        assign data_flat[i*DATA_W +: DATA_W] = data_q;
    end

    // Present the slot selected by rd_idx (the head).
    always_comb begin
        rd_vld   = vld_vec[rd_idx];
        rd_done  = done_vec[rd_idx];
        rd_exc   = exc_vec[rd_idx];
        rd_store = store_vec[rd_idx];
        rd_dst   = dst_flat[rd_idx*REG_W +: REG_W];
        rd_pc    = pc_flat[rd_idx*PC_W +: PC_W];
        rd_data  = data_flat[rd_idx*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/rob_squash_sel.sv
// Module: picks the oldest mispredicted branch among the completion ports
// and builds the mask of slots younger than it.
// Assumes: age is measured from head, so a smaller age is older.
module rob_squash_sel #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int PC_W  = 32,
    parameter int NCMP  = 2
) (
    input  logic                  en,
    input  logic [IDX_W-1:0]      head,
    input  logic [DEPTH-1:0]      vld_vec,
    input  logic [NCMP-1:0]       cmp_valid,
    input  logic [NCMP*IDX_W-1:0] cmp_tag,
    input  logic [NCMP-1:0]       cmp_mispred,
    input  logic [NCMP*PC_W-1:0]  cmp_target,
    output logic                  take,
    output logic [IDX_W-1:0]      br_idx,
    output logic [PC_W-1:0]       target,
    output logic [DEPTH-1:0]      squash_mask
);

    localparam logic [IDX_W:0] RING = (IDX_W+1)'(DEPTH);

    function automatic logic [IDX_W:0] age_of(input logic [IDX_W-1:0] t,
                                              input logic [IDX_W-1:0] h);
        return (t >= h) ? ({1'b0, t} - {1'b0, h}) : ({1'b0, t} + RING - {1'b0, h});
    endfunction

    logic [IDX_W:0] best_age;

    // Oldest flagged branch on a live slot wins.
    always_comb begin
        take     = 1'b0;
        br_idx   = '0;
        target   = '0;
        best_age = '0;
        for (int p = 0; p < NCMP; p++) begin
            if (en && cmp_valid[p] && cmp_mispred[p] && vld_vec[cmp_tag[p*IDX_W +: IDX_W]]) begin
                if (!take || age_of(cmp_tag[p*IDX_W +: IDX_W], head) < best_age) begin
                    take     = 1'b1;
                    br_idx   = cmp_tag[p*IDX_W +: IDX_W];
                    target   = cmp_target[p*PC_W +: PC_W];
                    best_age = age_of(cmp_tag[p*IDX_W +: IDX_W], head);
                end
            end
        end
    end

    // Every slot strictly younger than the chosen branch is squashed.
    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            squash_mask[i] = take && (age_of(IDX_W'(i), head) > best_age);
    end

endmodule

// File: rtl/rob_core.sv
// Module: reorder buffer top. Ring of DEPTH slots, single in-order retire,
// precise exception flush at the head, squash of younger entries on mispredict.
// Assumes: a tag on a completion port names a slot handed out by disp_tag;
// DEPTH is at least 2.
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int NCMP   = 2,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   disp_valid,
    output logic                   disp_ready,
    input  logic [REG_W-1:0]       disp_dst,
    input  logic [PC_W-1:0]        disp_pc,
    input  logic                   disp_store,
    output logic [IDX_W-1:0]       disp_tag,
    input  logic [NCMP-1:0]        cmp_valid,
    input  logic [NCMP*IDX_W-1:0]  cmp_tag,
    input  logic [NCMP*DATA_W-1:0] cmp_data,
    input  logic [NCMP-1:0]        cmp_exc,
    input  logic [NCMP-1:0]        cmp_mispred,
    input  logic [NCMP*PC_W-1:0]   cmp_target,
    output logic                   ret_valid,
    output logic [REG_W-1:0]       ret_dst,
    output logic [DATA_W-1:0]      ret_data,
    output logic [PC_W-1:0]        ret_pc,
    output logic                   ret_store,
    output logic                   exc_valid,
    output logic [PC_W-1:0]        exc_pc,
    output logic                   redir_valid,
    output logic [PC_W-1:0]        redir_pc,
    output logic                   rob_empty,
    output logic                   rob_full
);

    logic [IDX_W-1:0] head, tail, br_idx;
    logic             full, empty, push, mis_take;
    logic [DEPTH-1:0] vld_vec, squash_mask;
    logic             hd_vld, hd_done, hd_exc, hd_store;
    logic [REG_W-1:0] hd_dst;
    logic [PC_W-1:0]  hd_pc, mis_target;
    logic [DATA_W-1:0] hd_data;
    head_act_e        head_act;

    // Classify the head slot for this cycle.
    always_comb begin
        if (!hd_vld || !hd_done) head_act = HEAD_WAIT;
        else if (hd_exc)         head_act = HEAD_FAULT;
        else                     head_act = HEAD_COMMIT;
    end

    // Dispatch gating: full and either flush block it.
    always_comb begin
        disp_ready = !full && (head_act != HEAD_FAULT) && !mis_take;
        push       = disp_valid && disp_ready;
    end

    rob_ring_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (head_act == HEAD_COMMIT),
        .flush_all (head_act == HEAD_FAULT),
        .rewind    (mis_take),
        .rewind_to (br_idx),
        .head      (head),
        .tail      (tail),
        .full      (full),
        .empty     (empty)
    );

    rob_slot_array #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .REG_W(REG_W),
        .DATA_W(DATA_W), .PC_W(PC_W), .NCMP(NCMP)
    ) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (push),
        .wr_idx      (tail),
        .wr_dst      (disp_dst),
        .wr_pc       (disp_pc),
        .wr_store    (disp_store),
        .cmp_valid   (cmp_valid),
        .cmp_tag     (cmp_tag),
        .cmp_data    (cmp_data),
        .cmp_exc     (cmp_exc),
        .clear_all   (head_act == HEAD_FAULT),
        .squash_mask (squash_mask),
        .free_en     (head_act == HEAD_COMMIT),
        .free_idx    (head),
        .rd_idx      (head),
        .vld_vec     (vld_vec),
        .rd_vld      (hd_vld),
        .rd_done     (hd_done),
        .rd_exc      (hd_exc),
        .rd_dst      (hd_dst),
        .rd_pc       (hd_pc),
        .rd_store    (hd_store),
        .rd_data     (hd_data)
    );

    rob_squash_sel #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PC_W(PC_W), .NCMP(NCMP)) u_sel (
        .en          (head_act != HEAD_FAULT),
        .head        (head),
        .vld_vec     (vld_vec),
        .cmp_valid   (cmp_valid),
        .cmp_tag     (cmp_tag),
        .cmp_mispred (cmp_mispred),
        .cmp_target  (cmp_target),
        .take        (mis_take),
        .br_idx      (br_idx),
        .target      (mis_target),
        .squash_mask (squash_mask)
    );

    // Drive the retire, fault, redirect and status outputs.
    always_comb begin
        ret_valid   = (head_act == HEAD_COMMIT);
        ret_dst     = hd_dst;
        ret_data    = hd_data;
        ret_pc      = hd_pc;
        ret_store   = hd_store;
        exc_valid   = (head_act == HEAD_FAULT);
        exc_pc      = hd_pc;
        redir_valid = mis_take;
        redir_pc    = mis_target;
        rob_empty   = empty;
        rob_full    = full;
        disp_tag    = tail;
    end

endmodule

// File: rtl/rob_core_checker.sv
// Module: cycle-level properties of rob_core, attached by bind.
// Assumes: observes port-level signals only.
module rob_core_checker #(
    parameter int DEPTH  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [IDX_W-1:0] disp_tag,
    input logic             ret_valid,
    input logic             exc_valid,
    input logic             redir_valid,
    input logic             rob_empty,
    input logic             rob_full
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    p_empty_not_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(rob_empty && rob_full));

    p_empty_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rob_empty |-> (!ret_valid && !exc_valid));

    p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rob_full |-> !disp_ready);

    p_tag_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=>
            disp_tag == (($past(disp_tag) == LAST) ? '0 : $past(disp_tag) + 1'b1));

    p_tag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(disp_valid && disp_ready) && !exc_valid && !redir_valid) |=> $stable(disp_tag));

    p_single_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ret_valid, exc_valid}));

    p_fault_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> rob_empty);

    p_flush_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid || redir_valid) |-> !disp_ready);

endmodule

bind rob_core rob_core_checker #(.DEPTH(DEPTH)) u_rob_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_valid  (disp_valid),
    .disp_ready  (disp_ready),
    .disp_tag    (disp_tag),
    .ret_valid   (ret_valid),
    .exc_valid   (exc_valid),
    .redir_valid (redir_valid),
    .rob_empty   (rob_empty),
    .rob_full    (rob_full)
);

// File: tb/tb_rob_core.sv
// Bench for rob_core: table-driven scenarios against a requirement model,
// then directed corner cases.
module tb_rob_core;

    localparam int DEPTH  = 8;
    localparam int IDX_W  = 3;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;
    localparam int PC_W   = 32;
    localparam int NCMP   = 2;
    localparam int NONE   = 15;

    // Scenario rows: [15:12] entry count, [11:8] faulting index, [7:4] mispredicted index, [3:0] seed.
    localparam logic [15:0] SCEN [8] = '{
        16'h5FF3, 16'h72F5, 16'h6F17, 16'h7549,
        16'h3FFA, 16'h7F6C, 16'h41F2, 16'h7F0E
    };

    logic                   clk, rst_n;
    logic                   disp_valid, disp_ready, disp_store;
    logic [REG_W-1:0]       disp_dst;
    logic [PC_W-1:0]        disp_pc;
    logic [IDX_W-1:0]       disp_tag;
    logic [NCMP-1:0]        cmp_valid, cmp_exc, cmp_mispred;
    logic [NCMP*IDX_W-1:0]  cmp_tag;
    logic [NCMP*DATA_W-1:0] cmp_data;
    logic [NCMP*PC_W-1:0]   cmp_target;
    logic                   ret_valid, ret_store, exc_valid, redir_valid, rob_empty, rob_full;
    logic [REG_W-1:0]       ret_dst;
    logic [DATA_W-1:0]      ret_data;
    logic [PC_W-1:0]        ret_pc, exc_pc, redir_pc;

    rob_core #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W), .NCMP(NCMP)) dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_dst(disp_dst),
        .disp_pc(disp_pc), .disp_store(disp_store), .disp_tag(disp_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
        .cmp_exc(cmp_exc), .cmp_mispred(cmp_mispred), .cmp_target(cmp_target),
        .ret_valid(ret_valid), .ret_dst(ret_dst), .ret_data(ret_data),
        .ret_pc(ret_pc), .ret_store(ret_store),
        .exc_valid(exc_valid), .exc_pc(exc_pc),
        .redir_valid(redir_valid), .redir_pc(redir_pc),
        .rob_empty(rob_empty), .rob_full(rob_full)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model of the ring, driven only by the requirements.
    logic              m_vld [DEPTH];
    logic              m_done[DEPTH];
    logic              m_exc [DEPTH];
    logic              m_st  [DEPTH];
    logic [REG_W-1:0]  m_dst [DEPTH];
    logic [PC_W-1:0]   m_pc  [DEPTH];
    logic [DATA_W-1:0] m_data[DEPTH];
    int                m_head, m_tail;

    function automatic int nx(input int p);
        return (p + 1) % DEPTH;
    endfunction

    function automatic int age(input int t);
        return (t - m_head + DEPTH) % DEPTH;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_in();
        disp_valid  = 1'b0;
        cmp_valid   = '0;
        cmp_exc     = '0;
        cmp_mispred = '0;
    endtask

    task automatic set_cmp(input int p, input int tag, input logic [DATA_W-1:0] d,
                           input logic e, input logic m, input logic [PC_W-1:0] tg);
        cmp_valid[p]                  = 1'b1;
        cmp_tag[p*IDX_W +: IDX_W]     = IDX_W'(tag);
        cmp_data[p*DATA_W +: DATA_W]  = d;
        cmp_exc[p]                    = e;
        cmp_mispred[p]                = m;
        cmp_target[p*PC_W +: PC_W]    = tg;
    endtask

    // One clock: compare outputs with the model, take the edge, update the model.
    task automatic cycle();
        bit fault, commit, full, empty, mis, rdy;
        int br, best, t;
        logic [PC_W-1:0] tgt;
        #1;
        empty  = (m_head == m_tail);
        full   = (nx(m_tail) == m_head);
        fault  = m_vld[m_head] && m_done[m_head] && m_exc[m_head];
        commit = m_vld[m_head] && m_done[m_head] && !m_exc[m_head];
        mis = 0; br = 0; best = 0; tgt = '0;
        for (int p = 0; p < NCMP; p++) begin
            t = int'(cmp_tag[p*IDX_W +: IDX_W]);
            if (!fault && cmp_valid[p] && cmp_mispred[p] && m_vld[t] && (!mis || age(t) < best)) begin
                mis = 1; br = t; best = age(t); tgt = cmp_target[p*PC_W +: PC_W];
            end
        end
        rdy = !full && !fault && !mis;
        chk("R1", "rob_empty", 64'(rob_empty), 64'(empty));
        chk("R2", "rob_full", 64'(rob_full), 64'(full));
        chk("R9", "disp_ready", 64'(disp_ready), 64'(rdy));
        chk("R3", "disp_tag", 64'(disp_tag), 64'(m_tail));
        chk("R4", "ret_valid", 64'(ret_valid), 64'(commit));
        if (commit) begin
            chk("R4", "ret_dst", 64'(ret_dst), 64'(m_dst[m_head]));
            chk("R4", "ret_pc", 64'(ret_pc), 64'(m_pc[m_head]));
            chk("R4", "ret_store", 64'(ret_store), 64'(m_st[m_head]));
            chk("R11", "ret_data", 64'(ret_data), 64'(m_data[m_head]));
        end
        chk("R5", "exc_valid", 64'(exc_valid), 64'(fault));
        if (fault) chk("R5", "exc_pc", 64'(exc_pc), 64'(m_pc[m_head]));
        chk("R6", "redir_valid", 64'(redir_valid), 64'(mis));
        if (mis) chk("R7", "redir_pc", 64'(redir_pc), 64'(tgt));
        @(posedge clk);
        if (fault) begin
            for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
            m_tail = m_head;
        end else begin
            for (int p = 0; p < NCMP; p++) begin
                t = int'(cmp_tag[p*IDX_W +: IDX_W]);
                if (cmp_valid[p] && m_vld[t]) begin
                    m_done[t] = 1'b1;
                    m_exc[t]  = cmp_exc[p];
                    m_data[t] = cmp_data[p*DATA_W +: DATA_W];
                end
            end
            if (mis) begin
                for (int i = 0; i < DEPTH; i++)
                    if (age(i) > best) m_vld[i] = 1'b0;
                m_tail = nx(br);
            end else if (disp_valid && rdy) begin
                m_vld[m_tail] = 1'b1; m_done[m_tail] = 1'b0; m_exc[m_tail] = 1'b0;
                m_dst[m_tail] = disp_dst; m_pc[m_tail] = disp_pc; m_st[m_tail] = disp_store;
                m_tail = nx(m_tail);
            end
            if (commit) begin
                m_vld[m_head] = 1'b0;
                m_head = nx(m_head);
            end
        end
        @(negedge clk);
    endtask

    task automatic dispatch(input logic [REG_W-1:0] d, input logic [PC_W-1:0] pc,
                            input logic st, output int tag);
        tag        = m_tail;
        disp_valid = 1'b1;
        disp_dst   = d;
        disp_pc    = pc;
        disp_store = st;
        cycle();
        idle_in();
    endtask

    task automatic drain();
        int g;
        g = 0;
        while (m_head != m_tail && g < 40) begin
            cycle();
            g++;
        end
    endtask

    task automatic run_row(input int row, input logic [15:0] r);
        int n, ea, ma, k, j, tmp;
        int tags[8];
        int ord[8];
        logic [7:0] lf;
        n  = int'(r[15:12]);
        ea = int'(r[11:8]);
        ma = int'(r[7:4]);
        lf = {4'h9, r[3:0]};
        for (int i = 0; i < n; i++) begin
            dispatch(REG_W'(row * 3 + i), PC_W'(32'h1000 + row * 64 + i * 4), i[0], tags[i]);
            ord[i] = i;
        end
        for (int i = n - 1; i > 0; i--) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            j = int'(lf) % (i + 1);
            tmp = ord[i]; ord[i] = ord[j]; ord[j] = tmp;
        end
        k = 0;
        while (k < n) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            set_cmp(0, tags[ord[k]], DATA_W'(32'hA000_0000 + row * 256 + ord[k]),
                    ord[k] == ea, ord[k] == ma, PC_W'(32'h8000 + row));
            if (k + 1 < n && lf[0]) begin
                set_cmp(1, tags[ord[k+1]], DATA_W'(32'hA000_0000 + row * 256 + ord[k+1]),
                        ord[k+1] == ea, ord[k+1] == ma, PC_W'(32'h8000 + row));
                k += 2;
            end else begin
                k += 1;
            end
            cycle();
            idle_in();
        end
        drain();
    endtask

    initial begin
        #1_500_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int t[8];
        int dummy;
        idle_in();
        rst_n = 1'b0; disp_dst = '0; disp_pc = '0; disp_store = 1'b0;
        cmp_tag = '0; cmp_data = '0; cmp_target = '0;
        for (int i = 0; i < DEPTH; i++) begin
            m_vld[i] = 1'b0; m_done[i] = 1'b0; m_exc[i] = 1'b0;
        end
        m_head = 0; m_tail = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset empty", 64'(rob_empty), 64'd1);
        chk("R1", "reset full", 64'(rob_full), 64'd0);
        chk("R1", "reset ret_valid", 64'(ret_valid), 64'd0);
        chk("R3", "reset tag", 64'(disp_tag), 64'd0);
        rst_n = 1'b1;
        cycle();

        // Table-driven scenarios: shuffled completion, faults, mispredicts (R4 R5 R6 R10 R11).
        for (int row = 0; row < 8; row++)
            run_row(row, SCEN[row]);

        // R2: fill to DEPTH-1, one more dispatch is refused.
        for (int i = 0; i < DEPTH; i++)
            dispatch(REG_W'(20 + i), PC_W'(32'h2000 + i * 4), 1'b0, t[i]);
        chk("R2", "full flag", 64'(rob_full), 64'd1);
        chk("R2", "tag held when full", 64'(disp_tag), 64'(t[DEPTH-2] == DEPTH - 1 ? 0 : t[DEPTH-2] + 1));
        for (int i = DEPTH - 2; i >= 0; i--) begin
            set_cmp(0, t[i], DATA_W'(32'hB000 + i), 1'b0, 1'b0, '0);
            cycle();
            idle_in();
        end
        drain();

        // R8: retire and dispatch in the same cycle.
        dispatch(5'd1, 32'h3000, 1'b0, t[0]);
        dispatch(5'd2, 32'h3004, 1'b1, t[1]);
        set_cmp(0, t[0], 32'hC0, 1'b0, 1'b0, '0);
        cycle();
        idle_in();
        disp_valid = 1'b1; disp_dst = 5'd3; disp_pc = 32'h3008; disp_store = 1'b0;
        t[2] = m_tail;
        #1;
        chk("R8", "retire this cycle", 64'(ret_valid), 64'd1);
        chk("R8", "dispatch accepted", 64'(disp_ready), 64'd1);
        cycle();
        idle_in();
        set_cmp(0, t[1], 32'hC1, 1'b0, 1'b0, '0);
        set_cmp(1, t[2], 32'hC2, 1'b0, 1'b0, '0);
        cycle();
        idle_in();
        drain();

        // R7, R6, R10: two mispredicts at once, then a late completion to a squashed slot.
        for (int i = 0; i < 5; i++)
            dispatch(REG_W'(8 + i), PC_W'(32'h4000 + i * 4), 1'b0, t[i]);
        set_cmp(0, t[3], 32'hD3, 1'b0, 1'b1, 32'h5300);
        set_cmp(1, t[1], 32'hD1, 1'b0, 1'b1, 32'h5100);
        #1;
        chk("R7", "oldest redirect wins", 64'(redir_pc), 64'h5100);
        cycle();
        idle_in();
        chk("R6", "tail after branch", 64'(disp_tag), 64'(t[2]));
        set_cmp(0, t[2], 32'hDEAD, 1'b0, 1'b0, '0);
        cycle();
        idle_in();
        dispatch(5'd30, 32'h4100, 1'b0, dummy);
        set_cmp(0, t[0], 32'hD0, 1'b0, 1'b0, '0);
        cycle();
        idle_in();
        cycle();
        cycle();
        chk("R10", "squashed-slot completion ignored", 64'(ret_valid), 64'd0);
        chk("R10", "new entry still held", 64'(rob_empty), 64'd0);
        set_cmp(0, dummy, 32'hE0, 1'b0, 1'b0, '0);
        cycle();
        idle_in();
        drain();

        // R5: fault at the head empties the buffer on the next cycle.
        dispatch(5'd4, 32'h6000, 1'b0, t[0]);
        dispatch(5'd5, 32'h6004, 1'b0, t[1]);
        set_cmp(0, t[1], 32'hF1, 1'b0, 1'b0, '0);
        set_cmp(1, t[0], 32'hF0, 1'b1, 1'b0, '0);
        cycle();
        idle_in();
        #1;
        chk("R5", "fault pc", 64'(exc_pc), 64'h6000);
        cycle();
        chk("R5", "empty after fault", 64'(rob_empty), 64'd1);
        cycle();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule